// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox Controller

This block lets the four cores of a node interrupt one another. Each core owns a bank of registers. The bank holds a word of pending interrupt types, a per-type enable mask, a port that raises types when ones are written to it, a port that retires types when ones are written to it, and a small mailbox that carries data with the interrupt. Every bank is reachable from one shared register bus, so any core can raise types in any other core's bank and leave a message in that core's mailbox.

A sender fills the target's mailbox and then writes the target's raise port. The target sees its interrupt line go high. It reads its pending word and its mailbox, then writes the serviced bits to its retire port. Each core has one interrupt line. The line is registered and stays high while at least one pending type is also enabled.

Bus reads return data one cycle after the request, together with a one-cycle valid pulse. A write completes in the cycle it is presented. The register bus always accepts requests, so there is no back-pressure: a request is taken in every cycle that `bus_en` is high.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: After reset, every bank's pending word, enable mask and mailbox halves are zero, every interrupt line is low, and `bus_rvalid` is low.
- R2: Writing the raise port (bank offset 0x08) makes pending every bit that is one in the write data. Bits written as zero keep their value.
- R3: Writing the retire port (bank offset 0x0C) clears every pending bit that is one in the write data. Bits written as zero keep their value.
- R4: The pending word reads at offset 0x00, and writes to that offset have no effect. The enable mask reads and writes at offset 0x04.
- R5: The raise and retire ports always read as zero.
- R6: The interrupt line of core k is high exactly one cycle after a cycle in which core k's pending word ANDed with its enable mask is non-zero.
- R7: A type can become pending while it is disabled. Enabling it later raises the interrupt line.
- R8: Each mailbox holds 8 entries of 64 bits. They are accessed as 16 words of 32 bits at offsets 0x20 + 4*h, h = 0..15, where entry e has its low half at h = 2e and its high half at h = 2e+1. The mailbox is readable and writable.
- R9: Address bits [9:8] select the bank of core 0..3 (bank stride 0x100). A write changes only the bank it selects.
- R10: A read request (`bus_en` high, `bus_we` low) produces `bus_rvalid` high with the data in the next cycle. `bus_rvalid` is low in every other cycle.
- R11: Offsets outside the registers above, and addresses with bits [1:0] not zero, read as zero. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Request strobe, accepted every cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address: bank in [9:8], register offset in [7:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | One-cycle pulse, one cycle after a read request |
| irq | output | 4 | One interrupt line per core |

## Verification
The assertions assume that reset is held low for at least one clock edge before the first request. They also assume that `bus_we`, `bus_addr` and `bus_wdata` are known in every cycle where `bus_en` is high, because the raise, retire and read-zero properties decode those pins directly. The bench changes inputs only on the falling edge, holds reset for several cycles, and drives defined values on every pin at all times. Its random addresses are drawn from the mapped offsets plus one unmapped word of each bank, so every request decodes to a known register class.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [2:0] {
    RK_STATUS,
    RK_ENABLE,
    RK_SET,
    RK_CLEAR,
    RK_MBOX,
    RK_NONE
  } reg_kind_e;

  // word indices inside one bank (byte offset / 4)
  localparam int unsigned WIDX_STATUS = 0;
  localparam int unsigned WIDX_ENABLE = 1;
  localparam int unsigned WIDX_SET    = 2;
  localparam int unsigned WIDX_CLEAR  = 3;
  localparam int unsigned WIDX_MBOX   = 8;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int BANK_SHIFT  = 8,
  parameter int MBOX_HALVES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int MB_W   = $clog2(MBOX_HALVES),
  localparam int ADDR_W = BANK_SHIFT + CORE_W,
  localparam int WIDX_W = BANK_SHIFT - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CORE_W-1:0] core_sel,
  output reg_kind_e         kind,
  output logic [MB_W-1:0]   mbox_idx
);
  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] mb_off;

  assign core_sel = addr[ADDR_W-1:BANK_SHIFT];
  assign widx     = addr[BANK_SHIFT-1:2];
  assign mb_off   = widx - WIDX_W'(WIDX_MBOX);
  assign mbox_idx = mb_off[MB_W-1:0];

  always_comb begin
    kind = RK_NONE;
    if (addr[1:0] == 2'b00) begin
      if (widx == WIDX_W'(WIDX_STATUS))      kind = RK_STATUS;
      else if (widx == WIDX_W'(WIDX_ENABLE)) kind = RK_ENABLE;
      else if (widx == WIDX_W'(WIDX_SET))    kind = RK_SET;
      else if (widx == WIDX_W'(WIDX_CLEAR))  kind = RK_CLEAR;
      else if (widx >= WIDX_W'(WIDX_MBOX) &&
               widx <  WIDX_W'(WIDX_MBOX + MBOX_HALVES)) kind = RK_MBOX;
    end
  end
endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
  import ipi_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int MBOX_HALVES = 16,
  localparam int MB_W = $clog2(MBOX_HALVES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [MB_W-1:0]   mbox_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] enable_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] mbox_q [MBOX_HALVES];
  logic              irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      for (int i = 0; i < MBOX_HALVES; i++) mbox_q[i] <= '0;
    end else if (wr_en) begin
      case (kind)
        RK_SET:    status_q         <= status_q | wdata;
        RK_CLEAR:  status_q         <= status_q & ~wdata;
        RK_ENABLE: enable_q         <= wdata;
        RK_MBOX:   mbox_q[mbox_idx] <= wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_q & enable_q);
  end

  always_comb begin
    case (kind)
      RK_STATUS: rd_data = status_q;
      RK_ENABLE: rd_data = enable_q;
      RK_MBOX:   rd_data = mbox_q[mbox_idx];
      default:   rd_data = '0;
    endcase
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int DATA_W      = 32,
  parameter int BANK_SHIFT  = 8,
  parameter int MBOX_HALVES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int MB_W   = $clog2(MBOX_HALVES),
  localparam int ADDR_W = BANK_SHIFT + CORE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_CORES-1:0] irq
);
  logic [CORE_W-1:0] core_sel;
  reg_kind_e         kind;
  logic [MB_W-1:0]   mbox_idx;

  logic [NUM_CORES-1:0][DATA_W-1:0] bank_rd;
  logic [NUM_CORES-1:0][DATA_W-1:0] status_vec;
  logic [NUM_CORES-1:0][DATA_W-1:0] enable_vec;

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  ipi_addr_decode #(
    .NUM_CORES(NUM_CORES), .BANK_SHIFT(BANK_SHIFT), .MBOX_HALVES(MBOX_HALVES)
  ) u_dec (
    .addr(bus_addr), .core_sel(core_sel), .kind(kind), .mbox_idx(mbox_idx)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_bank
    logic wr_sel;
    assign wr_sel = bus_en && bus_we && (core_sel == CORE_W'(g));
    ipi_core_bank #(.DATA_W(DATA_W), .MBOX_HALVES(MBOX_HALVES)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_sel), .kind(kind),
      .mbox_idx(mbox_idx), .wdata(bus_wdata), .rd_data(bank_rd[g]),
      .status_o(status_vec[g]), .enable_o(enable_vec[g]), .irq_o(irq[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_en && !bus_we;
      if (bus_en && !bus_we) rdata_q <= bank_rd[core_sel];
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/ipi_mailbox_ctrl_chk.sv
module ipi_mailbox_ctrl_chk #(
  parameter int NUM_CORES  = 4,
  parameter int DATA_W     = 32,
  parameter int BANK_SHIFT = 8,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int ADDR_W = BANK_SHIFT + CORE_W
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_en,
  input logic                             bus_we,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic [DATA_W-1:0]                bus_wdata,
  input logic [DATA_W-1:0]                bus_rdata,
  input logic                             bus_rvalid,
  input logic [NUM_CORES-1:0]             irq,
  input logic [NUM_CORES-1:0][DATA_W-1:0] status_vec,
  input logic [NUM_CORES-1:0][DATA_W-1:0] enable_vec
);
  logic [CORE_W-1:0]     cs;
  logic [BANK_SHIFT-1:0] off;
  logic                  rd_req, wr_set, wr_clr, rd_setclr;

  assign cs        = bus_addr[ADDR_W-1:BANK_SHIFT];
  assign off       = bus_addr[BANK_SHIFT-1:0];
  assign rd_req    = bus_en && !bus_we;
  assign wr_set    = bus_en && bus_we && (off == BANK_SHIFT'(8'h08));
  assign wr_clr    = bus_en && bus_we && (off == BANK_SHIFT'(8'h0C));
  assign rd_setclr = rd_req && (off == BANK_SHIFT'(8'h08) || off == BANK_SHIFT'(8'h0C));

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R10
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid); // R10
  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_setclr |=> (bus_rdata == '0)); // R5
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((status_vec[$past(cs)] & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_CLEAR_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((status_vec[$past(cs)] & $past(bus_wdata)) == '0)); // R3

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_irq
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq[g] == $past(|(status_vec[g] & enable_vec[g])))); // R6
  end
endmodule

bind ipi_mailbox_ctrl ipi_mailbox_ctrl_chk #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .BANK_SHIFT(BANK_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .irq(irq), .status_vec(status_vec),
  .enable_vec(enable_vec)
);

// File: tb/ipi_mailbox_ctrl_tb.sv
`timescale 1ns/1ps
module ipi_mailbox_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_status [4];
  logic [31:0] m_enable [4];
  logic [31:0] m_mbox   [4][16];

  always #2 clk = ~clk;

  ipi_mailbox_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    int c = int'(a[9:8]);
    int w = int'(a[7:2]);
    if (a[1:0] != 2'b00) return '0;
    if (w == 0) return m_status[c];
    if (w == 1) return m_enable[c];
    if (w >= 8 && w < 24) return m_mbox[c][w-8];
    return '0;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = |(m_status[c] & m_enable[c]);
    return r;
  endfunction

  task automatic model_write(input logic [9:0] a, input logic [31:0] d);
    int c = int'(a[9:8]);
    int w = int'(a[7:2]);
    if (a[1:0] != 2'b00) return;
    if (w == 1) m_enable[c] = d;
    else if (w == 2) m_status[c] = m_status[c] | d;
    else if (w == 3) m_status[c] = m_status[c] & ~d;
    else if (w >= 8 && w < 24) m_mbox[c][w-8] = d;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    model_write(a, d);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    e = exp_read(a);
    @(posedge clk);
    #1;
    check(bus_rvalid == 1'b1, "R10 rvalid", {31'd0, bus_rvalid}, 32'd1);
    check(bus_rdata == e, req, bus_rdata, e);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  // one idle edge, then irq reflects the state updated one cycle earlier
  task automatic check_irq(input string req);
    logic [3:0] e;
    @(negedge clk);
    bus_en = 1'b0;
    e = exp_irq();
    @(posedge clk);
    #1;
    check(irq == e, req, {28'd0, irq}, {28'd0, e});
    check(bus_rvalid == 1'b0, "R10 no rvalid when idle", {31'd0, bus_rvalid}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin
      m_status[c] = '0; m_enable[c] = '0;
      for (int h = 0; h < 16; h++) m_mbox[c][h] = '0;
    end
    repeat (4) @(posedge clk);
    #1;
    check(irq == 4'd0, "R1 irq after reset", {28'd0, irq}, 32'd0);
    check(bus_rvalid == 1'b0, "R1 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      bus_read({c[1:0], 8'h00}, "R1 status reset");
      bus_read({c[1:0], 8'h04}, "R1 enable reset");
      bus_read({c[1:0], 8'h20}, "R1 mailbox first half reset");
      bus_read({c[1:0], 8'h5C}, "R1 mailbox last half reset");
    end

    // R7: pending while disabled, no irq
    bus_write(10'h108, 32'h0000_0005);
    bus_read(10'h100, "R2 set raises bits");
    check_irq("R7 disabled type gives no irq");
    bus_write(10'h104, 32'h0000_0004);
    bus_read(10'h104, "R4 enable readback");
    check_irq("R7 enabling pending type raises irq");
    check_irq("R6 irq stays high while enabled pending");
    // R2: zeros do nothing
    bus_write(10'h108, 32'h0000_0000);
    bus_read(10'h100, "R2 zero write keeps status");
    // R4: status offset not writable
    bus_write(10'h100, 32'hFFFF_FFFF);
    bus_read(10'h100, "R4 status ignores writes");
    // R5
    bus_read(10'h108, "R5 set port reads zero");
    bus_read(10'h10C, "R5 clear port reads zero");
    // R3
    bus_write(10'h10C, 32'h0000_0000);
    bus_read(10'h100, "R3 zero clear keeps status");
    bus_write(10'h10C, 32'h0000_0004);
    bus_read(10'h100, "R3 clear retires bit");
    check_irq("R6 irq drops after clear");
    // R8 mailbox halves
    bus_write(10'h220, 32'hDEAD_0001);
    bus_write(10'h224, 32'hBEEF_0002);
    bus_write(10'h25C, 32'hCAFE_000F);
    bus_read(10'h220, "R8 entry0 low half");
    bus_read(10'h224, "R8 entry0 high half");
    bus_read(10'h25C, "R8 entry7 high half");
    // R9 cross-bank isolation
    bus_write(10'h304, 32'hFFFF_FFFF);
    bus_write(10'h308, 32'h8000_0000);
    check_irq("R9 only core3 irq");
    bus_read(10'h000, "R9 core0 status untouched");
    bus_read(10'h020, "R9 core0 mailbox untouched");
    bus_read(10'h300, "R9 core3 status set");
    // R11 unmapped and misaligned
    bus_write(10'h010, 32'h1234_5678);
    bus_read(10'h010, "R11 unmapped reads zero");
    bus_write(10'h221, 32'h5555_5555);
    bus_read(10'h220, "R11 misaligned write ignored");
    bus_read(10'h222, "R11 misaligned read zero");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int pick = int'($urandom_range(0, 20));
      int w;
      logic [1:0] c = 2'($urandom_range(0, 3));
      logic [31:0] d;
      logic [9:0] a;
      if (pick < 4) w = pick;
      else if (pick == 4) w = 5;
      else w = 8 + (pick - 5);
      a = {c, 2'b00, 6'(w)} ;
      a = {c, 6'(w), 2'b00};
      d = $urandom & $urandom;
      if ($urandom_range(0, 2) == 0) bus_read(a, "R2 R3 R4 R8 random read");
      else begin
        bus_write(a, d);
        check_irq("R6 random irq");
      end
    end
    for (int c = 0; c < 4; c++) bus_read({c[1:0], 8'h00}, "R9 final status per core");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule